// File: doc/BRIEF.md
# JTAG Serial Character Channel Data Register

This block carries a byte stream between a debug host and target logic through a single JTAG data register. Each scan is a full-duplex exchange. The host shifts in one header byte and eight payload bytes. At the same time it receives a header byte and eight payload bytes prepared by the block. The outgoing header's upper nibble says how many payload bytes are characters to deliver to the target. The returned header's upper nibble says how many received characters follow. Its lower nibble reports the free space in the host-to-target queue. No separate status access is needed.

On the target side there are two byte queues, each with a valid/ready handshake. One holds characters from the host. The other collects characters that the target produces for the host. The TAP controller's capture, shift and update steps arrive as single-cycle strobes in the block's clock domain, together with the serial data in and out. Returned characters are loaded at capture. They leave their queue only when a complete scan reaches update. The same update delivers the host's characters, as many as the free space reported at capture allows.

Top module: `jsp_dr`

## Requirements
- R1: After synchronous reset, `h2t_valid` is 0, `t2h_ready` is 1 and `tdo` is 0.
- R2: On capture the returned header (frame bits 7:0) holds, in bits 7:4, the number of queued target-to-host bytes (capped at 8) and, in bits 3:0, the free space of the host-to-target queue (capped at 8).
- R3: On capture payload byte k (frame bits 8k+15:8k+8, k = 0..7) holds the k-th oldest queued target-to-host byte for k below the reported count and zero otherwise. The frame leaves on `tdo` least significant bit first, one bit per shift cycle.
- R4: At update after a full 72-bit scan, the first min(write count, reported free, 8) payload bytes are pushed into the host-to-target queue in payload order. The write count is bits 7:4 of the incoming header.
- R5: At update after a full scan, exactly the number of bytes reported in the returned header is removed from the target-to-host queue.
- R6: Shift cycles after the 72nd bit change neither the frame nor the result of the update, whatever value `tdi` carries.
- R7: An update that follows fewer than 72 shifted bits pushes and pops nothing.
- R8: Write-count bytes beyond the reported free space are dropped, and the bytes within it are kept.
- R9: A target push or a host-to-target pop in the same cycle as an update takes effect together with the update's pops and pushes.
- R10: `t2h_ready` is 0 while the target-to-host queue holds 8 bytes, and a byte offered then is not stored.
- R11: The host-to-target queue presents bytes on `h2t_data` in arrival order and drops one per cycle in which `h2t_valid` and `h2t_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_capture | input | 1 | Capture strobe: load the returned frame |
| tap_shift | input | 1 | Shift strobe: move one bit in and out |
| tap_update | input | 1 | Update strobe: commit pushes and pops |
| tdi | input | 1 | Serial data from the host |
| tdo | output | 1 | Serial data to the host |
| h2t_valid | output | 1 | Host-to-target byte available |
| h2t_data | output | 8 | Host-to-target byte |
| h2t_ready | input | 1 | Target takes the host-to-target byte |
| t2h_valid | input | 1 | Target offers a byte for the host |
| t2h_data | input | 8 | Byte for the host |
| t2h_ready | output | 1 | Target-to-host queue can accept a byte |

## Verification
The update strobe can coincide with a target push into the target-to-host queue. It can also coincide with the target draining the host-to-target queue. The bench raises `t2h_valid` and `h2t_ready` in the very cycle it raises the update strobe, with the host-to-target queue already holding a byte. The scoreboard then requires the old byte to leave first and the newly written byte to follow. The next scan must report exactly the byte pushed during the update as available.

// File: rtl/jsp_pkg.sv
`timescale 1ns/1ps
package jsp_pkg;

    localparam int BYTE_W      = 8;
    localparam int JSP_DEPTH   = 8;
    localparam int JSP_PAYLOAD = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Header byte: upper nibble is a count, lower nibble is free space
    typedef struct packed {
        logic [3:0] hi;
        logic [3:0] lo;
    } hdr_t;

    function automatic int umin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/jsp_fifo.sv
`timescale 1ns/1ps
module jsp_fifo
    import jsp_pkg::*;
#(
    parameter int DEPTH = JSP_DEPTH,
    parameter int BULK  = JSP_PAYLOAD,
    parameter int WIN   = 1,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NW   = $clog2(BULK + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push_one,
    input  byte_t                    push_data,
    input  logic [NW-1:0]            push_many,
    input  logic [BULK-1:0][BYTE_W-1:0] push_bytes,
    input  logic                     pop_one,
    input  logic [NW-1:0]            pop_many,
    output logic [CW-1:0]            count,
    output logic [WIN-1:0][BYTE_W-1:0] window
);

    byte_t         mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] count_q;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input int n);
        int s;
        s = int'(p) + n;
        return PW'(s % DEPTH);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            for (int k = 0; k < BULK; k++) begin
                if (k < int'(push_many))
                    mem[adv(wr_q, k)] <= push_bytes[k];
            end
            if (push_one)
                mem[adv(wr_q, int'(push_many))] <= push_data;
            wr_q    <= adv(wr_q, int'(push_many) + int'(push_one));
            rd_q    <= adv(rd_q, int'(pop_many) + int'(pop_one));
            count_q <= CW'(int'(count_q) + int'(push_many) + int'(push_one)
                           - int'(pop_many) - int'(pop_one));
        end
    end

    generate
        for (genvar g = 0; g < WIN; g++) begin : g_win
            assign window[g] = mem[adv(rd_q, g)];
        end
    endgenerate

    assign count = count_q;

endmodule

// File: rtl/jsp_shifter.sv
`timescale 1ns/1ps
module jsp_shifter #(
    parameter int FRAME = 72,
    localparam int BCW  = $clog2(FRAME + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             shift,
    input  logic             update,
    input  logic [FRAME-1:0] load,
    input  logic             tdi,
    output logic             tdo,
    output logic [FRAME-1:0] frame_q,
    output logic             full
);

    logic [FRAME-1:0] sr_q;
    logic [BCW-1:0]   cnt_q;
    logic             room;

    assign room = (cnt_q < BCW'(FRAME));

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (capture) begin
            sr_q  <= load;
            cnt_q <= '0;
        end else if (shift && room) begin
            sr_q  <= {tdi, sr_q[FRAME-1:1]};
            cnt_q <= cnt_q + 1'b1;
        end else if (update) begin
            cnt_q <= '0;
        end
    end

    assign tdo     = room ? sr_q[0] : 1'b0;
    assign frame_q = sr_q;
    assign full    = !room;

endmodule

// File: rtl/jsp_dr.sv
`timescale 1ns/1ps
module jsp_dr
    import jsp_pkg::*;
#(
    parameter int DEPTH   = JSP_DEPTH,
    parameter int PAYLOAD = JSP_PAYLOAD
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tap_capture,
    input  logic        tap_shift,
    input  logic        tap_update,
    input  logic        tdi,
    output logic        tdo,
    output logic        h2t_valid,
    output logic [7:0]  h2t_data,
    input  logic        h2t_ready,
    input  logic        t2h_valid,
    input  logic [7:0]  t2h_data,
    output logic        t2h_ready
);

    localparam int FRAME = BYTE_W * (PAYLOAD + 1);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int NW    = $clog2(PAYLOAD + 1);

    logic [CW-1:0] h2t_count, t2h_count;
    logic [0:0][BYTE_W-1:0]         h2t_win;
    logic [PAYLOAD-1:0][BYTE_W-1:0] t2h_win;
    logic [PAYLOAD-1:0][BYTE_W-1:0] rx_bytes;
    logic [FRAME-1:0] frame_q, frame_load;
    logic             scan_full, do_upd;
    logic [NW-1:0]    now_avail, now_free, cap_avail, cap_free;
    logic [NW-1:0]    accept_n, push_n, pop_n;
    logic             h2t_pop, t2h_push;
    hdr_t             hdr_out, hdr_in;

    // Counts offered to the host at capture
    always_comb begin
        now_avail = NW'(umin(int'(t2h_count), PAYLOAD));
        now_free  = NW'(umin(DEPTH - int'(h2t_count), PAYLOAD));
        hdr_out   = '{hi: 4'(now_avail), lo: 4'(now_free)};
    end

    assign frame_load[BYTE_W-1:0] = hdr_out;

    generate
        for (genvar k = 0; k < PAYLOAD; k++) begin : g_pay
            assign frame_load[BYTE_W*(k+1) +: BYTE_W] =
                (NW'(k) < now_avail) ? t2h_win[k] : '0;
            assign rx_bytes[k] = frame_q[BYTE_W*(k+1) +: BYTE_W];
        end
    endgenerate

    // Snapshot of what was reported, used to commit at update
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_avail <= '0;
            cap_free  <= '0;
        end else if (tap_capture) begin
            cap_avail <= now_avail;
            cap_free  <= now_free;
        end
    end

    always_comb begin
        hdr_in   = hdr_t'(frame_q[BYTE_W-1:0]);
        accept_n = NW'(umin(umin(int'(hdr_in.hi), int'(cap_free)), PAYLOAD));
        do_upd   = tap_update && scan_full;
        push_n   = do_upd ? accept_n  : '0;
        pop_n    = do_upd ? cap_avail : '0;
    end

    assign h2t_valid = (h2t_count != '0);
    assign h2t_pop   = h2t_valid && h2t_ready;
    assign h2t_data  = h2t_win[0];
    assign t2h_ready = (t2h_count < CW'(DEPTH));
    assign t2h_push  = t2h_valid && t2h_ready;

    jsp_shifter #(.FRAME(FRAME)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .capture (tap_capture),
        .shift   (tap_shift),
        .update  (tap_update),
        .load    (frame_load),
        .tdi     (tdi),
        .tdo     (tdo),
        .frame_q (frame_q),
        .full    (scan_full)
    );

    jsp_fifo #(.DEPTH(DEPTH), .BULK(PAYLOAD), .WIN(1)) u_h2t (
        .clk        (clk),
        .rst        (rst),
        .push_one   (1'b0),
        .push_data  ('0),
        .push_many  (push_n),
        .push_bytes (rx_bytes),
        .pop_one    (h2t_pop),
        .pop_many   ('0),
        .count      (h2t_count),
        .window     (h2t_win)
    );

    jsp_fifo #(.DEPTH(DEPTH), .BULK(PAYLOAD), .WIN(PAYLOAD)) u_t2h (
        .clk        (clk),
        .rst        (rst),
        .push_one   (t2h_push),
        .push_data  (t2h_data),
        .push_many  ('0),
        .push_bytes ('0),
        .pop_one    (1'b0),
        .pop_many   (pop_n),
        .count      (t2h_count),
        .window     (t2h_win)
    );

endmodule

// File: rtl/jsp_dr_chk.sv
`timescale 1ns/1ps
module jsp_dr_chk #(
    parameter int DEPTH   = 8,
    parameter int PAYLOAD = 8,
    parameter int CW      = 4,
    parameter int FRAME   = 72
) (
    input logic             clk,
    input logic             rst,
    input logic             tap_capture,
    input logic             tap_shift,
    input logic             tap_update,
    input logic             t2h_valid,
    input logic             t2h_ready,
    input logic             h2t_valid,
    input logic             h2t_ready,
    input logic [CW-1:0]    t2h_count,
    input logic [CW-1:0]    h2t_count,
    input logic             scan_full,
    input logic [FRAME-1:0] frame_q
);

    function automatic logic [3:0] free_of(input logic [CW-1:0] c);
        int f;
        f = DEPTH - int'(c);
        if (f > PAYLOAD) f = PAYLOAD;
        return 4'(f);
    endfunction

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!h2t_valid && t2h_ready)); // R1

    AST_FREE_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        tap_capture |=> frame_q[3:0] == free_of($past(h2t_count))); // R2

    AST_H2T_BOUND: assert property (@(posedge clk) disable iff (rst)
        h2t_count <= CW'(DEPTH)); // R4

    AST_TAIL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (tap_shift && !tap_capture && scan_full) |=> $stable(frame_q)); // R6

    AST_ABORT_NOPOP: assert property (@(posedge clk) disable iff (rst)
        (tap_update && !scan_full && !(t2h_valid && t2h_ready))
        |=> t2h_count == $past(t2h_count)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (t2h_count == CW'(DEPTH) && !tap_update) |=> t2h_count == CW'(DEPTH)); // R10

    AST_H2T_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (h2t_valid && h2t_ready && !tap_update)
        |=> h2t_count == CW'(int'($past(h2t_count)) - 1)); // R11

endmodule

bind jsp_dr jsp_dr_chk #(
    .DEPTH(DEPTH), .PAYLOAD(PAYLOAD), .CW(CW), .FRAME(FRAME)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tap_capture (tap_capture),
    .tap_shift   (tap_shift),
    .tap_update  (tap_update),
    .t2h_valid   (t2h_valid),
    .t2h_ready   (t2h_ready),
    .h2t_valid   (h2t_valid),
    .h2t_ready   (h2t_ready),
    .t2h_count   (t2h_count),
    .h2t_count   (h2t_count),
    .scan_full   (scan_full),
    .frame_q     (frame_q)
);

// File: tb/jsp_dr_tb.sv
`timescale 1ns/1ps
module jsp_dr_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tap_capture = 1'b0, tap_shift = 1'b0, tap_update = 1'b0;
    logic       tdi = 1'b0;
    logic       tdo;
    logic       h2t_valid;
    logic [7:0] h2t_data;
    logic       mon_rdy = 1'b0;
    logic       t2h_valid = 1'b0;
    logic [7:0] t2h_data = 8'h00;
    logic       t2h_ready;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] exp_q[$];   // expected host-to-target bytes (scoreboard)
    logic [7:0] t2h_q[$];   // model of target-to-host queue

    always #2.5 clk = ~clk;

    jsp_dr u_dut (
        .clk(clk), .rst(rst),
        .tap_capture(tap_capture), .tap_shift(tap_shift), .tap_update(tap_update),
        .tdi(tdi), .tdo(tdo),
        .h2t_valid(h2t_valid), .h2t_data(h2t_data), .h2t_ready(mon_rdy),
        .t2h_valid(t2h_valid), .t2h_data(t2h_data), .t2h_ready(t2h_ready)
    );

    task automatic check(input bit ok, input string what,
                         input logic [71:0] act, input logic [71:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Monitor: every handshake on the host-to-target side is scored
    always @(negedge clk) begin
        if (!rst && h2t_valid && mon_rdy) begin
            if (exp_q.size() == 0)
                check(1'b0, "R11 unexpected h2t byte", {64'h0, h2t_data}, 72'h0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(h2t_data == e, "R4/R11 h2t byte order", {64'h0, h2t_data}, {64'h0, e});
            end
        end
    end

    task automatic push_t2h(input logic [7:0] b, output bit acc);
        @(posedge clk); #1;
        t2h_valid = 1'b1; t2h_data = b;
        @(negedge clk); acc = t2h_ready;
        @(posedge clk); #1;
        t2h_valid = 1'b0;
        if (acc) t2h_q.push_back(b);
    endtask

    // Driver: one scan, expected results derived from the requirements
    task automatic scan(input logic [7:0] hdr, input logic [63:0] pay, input int nbits,
                        input int exp_free, input bit upd_push, input logic [7:0] upd_byte,
                        input bit upd_rdy, input string tag);
        logic [71:0] fr, got, expv, mask;
        int avail, acc;
        fr = {pay, hdr};
        got = '0; expv = '0; mask = '0;
        avail = (t2h_q.size() > 8) ? 8 : t2h_q.size();
        expv[7:4] = 4'(avail);
        expv[3:0] = 4'(exp_free);
        for (int k = 0; k < avail; k++) expv[8*(k+1) +: 8] = t2h_q[k];
        for (int i = 0; i < 72; i++) mask[i] = (i < nbits);
        @(posedge clk); #1; tap_capture = 1'b1;
        @(posedge clk); #1; tap_capture = 1'b0; tap_shift = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            tdi = (i < 72) ? fr[i] : 1'b1;
            @(negedge clk);
            if (i < 72) got[i] = tdo;
            @(posedge clk); #1;
        end
        tap_shift = 1'b0; tdi = 1'b0;
        check((got[7:0] & mask[7:0]) == (expv[7:0] & mask[7:0]),
              {tag, " R2 header"}, got & mask, expv & mask);
        check((got & mask) == (expv & mask), {tag, " R3 returned frame"}, got & mask, expv & mask);
        if (nbits >= 72) begin
            acc = int'(hdr[7:4]);
            if (acc > exp_free) acc = exp_free;
            if (acc > 8) acc = 8;
            for (int k = 0; k < acc; k++) exp_q.push_back(pay[8*k +: 8]);
            for (int k = 0; k < avail; k++) void'(t2h_q.pop_front());
        end
        tap_update = 1'b1;
        if (upd_push) begin
            t2h_valid = 1'b1; t2h_data = upd_byte;
            t2h_q.push_back(upd_byte);
        end
        if (upd_rdy) mon_rdy = 1'b1;
        @(posedge clk); #1;
        tap_update = 1'b0; t2h_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        mon_rdy = 1'b1;
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, {tag, " R11 queue drained"}, 72'(exp_q.size()), 72'h0);
        check(!h2t_valid, {tag, " R11 valid low when empty"}, 72'(h2t_valid), 72'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        bit acc;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!h2t_valid, "R1 h2t_valid after reset", 72'(h2t_valid), 72'h0);
        check(t2h_ready,  "R1 t2h_ready after reset", 72'(t2h_ready), 72'h1);
        check(!tdo,       "R1 tdo after reset", 72'(tdo), 72'h0);

        // Empty exchange
        scan(8'h00, 64'h0, 72, 8, 0, 8'h00, 0, "R2 empty");

        // Basic full duplex: three returned, two written
        push_t2h(8'hA1, acc); push_t2h(8'hB2, acc); push_t2h(8'hC3, acc);
        scan(8'h20, 64'h99887766_55442211, 72, 8, 0, 8'h00, 0, "R4 basic");
        drain("R4");
        scan(8'h00, 64'h0, 72, 8, 0, 8'h00, 0, "R5 after pop");

        // Write count limited by reported free space
        mon_rdy = 1'b0;
        scan(8'h50, 64'h00000005_04030201, 72, 8, 0, 8'h00, 0, "R8 five");
        scan(8'h60, 64'h00001514_13121110, 72, 3, 0, 8'h00, 0, "R8 free3");
        scan(8'h40, 64'hDEADBEEF_DEADBEEF, 72, 0, 0, 8'h00, 0, "R8 free0");
        drain("R8");

        // Aborted scan: nothing moves
        push_t2h(8'h5A, acc); push_t2h(8'h6B, acc);
        scan(8'h30, 64'h00000000_00CCBBAA, 40, 8, 0, 8'h00, 0, "R7 abort");
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!h2t_valid, "R7 no push on abort", 72'(h2t_valid), 72'h0);
        scan(8'h00, 64'h0, 72, 8, 0, 8'h00, 0, "R7 bytes kept");

        // Trailing bits beyond the frame
        scan(8'h80, 64'h80070605_04030201, 75, 8, 0, 8'h00, 0, "R6 tail");
        drain("R6");

        // Full target-to-host queue
        for (int i = 0; i < 8; i++) push_t2h(8'h40 + 8'(i), acc);
        @(negedge clk);
        check(!t2h_ready, "R10 ready low when full", 72'(t2h_ready), 72'h0);
        push_t2h(8'hEE, acc);
        check(!acc, "R10 byte refused when full", 72'(acc), 72'h0);
        scan(8'h00, 64'h0, 72, 8, 0, 8'h00, 0, "R10 read eight");
        @(negedge clk);
        check(t2h_ready, "R10 ready back after pop", 72'(t2h_ready), 72'h1);

        // Same-cycle events at update
        mon_rdy = 1'b0;
        scan(8'h10, 64'h00000000_00000077, 72, 8, 0, 8'h00, 0, "R9 preload");
        push_t2h(8'h31, acc); push_t2h(8'h32, acc);
        scan(8'h10, 64'h00000000_00000078, 72, 7, 1, 8'h33, 1, "R9 collide");
        scan(8'h00, 64'h0, 72, 8, 0, 8'h00, 0, "R9 after");
        drain("R9");
        check(t2h_q.size() == 0, "R5 model empty", 72'(t2h_q.size()), 72'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule